// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is a slave receiver for two-channel serial audio. It takes a bit clock, a frame clock that separates the left and right channels, and one serial data line. All three are sampled by the block's own system clock, which must run several times faster than the bit clock. Each received stereo sample comes out as two 24-bit words together with a one-cycle valid strobe.

A 3-bit format code selects the layout of the data within each half frame. The layout can be LSB-justified with 16, 20 or 24 bits, MSB-justified with 24 bits, or I2S-style, where the MSB arrives one bit clock late. The code is loaded only while the power-down input is high and is held once the block leaves power-down.

An error flag reports two cases: a reserved code, or a short 32-bit frame used with a layout that cannot fit in one. While the flag is set, both output words read zero. Power-down clears the flag.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, `left_word` and `right_word` are zero, and `word_valid` and `fmt_err` are low.
- R2: Data is captured on rising bit-clock edges, MSB first, in two's complement. With format code 0, 1 or 4, the word is taken from the last 16, 20 or 24 bits before the frame-clock edge. A high frame clock marks the left half.
- R3: With format code 2 or 5 (MSB-justified), the word is taken from the first bits after the frame-clock edge, up to 24 of them. A high frame clock marks the left half.
- R4: With format code 3 or 6 (I2S-style), the MSB arrives one bit clock after the frame-clock edge. A low frame clock marks the left half.
- R5: A word shorter than 24 bits is placed at the top of the 24-bit output, and the low bits are filled with zeros. This covers 16- and 20-bit formats and MSB-aligned halves that carry only 16 or 20 bits.
- R6: `word_valid` pulses high for exactly one system-clock cycle per received frame. Both words are updated in that same cycle.
- R7: The format code is loaded only while `pwr_dn` is high. A change to `fmt_sel` while `pwr_dn` is low has no effect.
- R8: Format code 7 is reserved. If it is loaded, `fmt_err` goes high right after power-down is released.
- R9: A 32-bit frame (16 bits per half) sets `fmt_err` unless the format code is 0 or 3. While `fmt_err` is high, both output words are zero.
- R10: While `pwr_dn` is high, `fmt_err`, `word_valid` and both words are cleared.
- R11: Frames of 32, 40, 48 and 64 bit clocks are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be much faster than the bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down: clears the receiver and loads `fmt_sel` |
| fmt_sel | input | 3 | Format code, loaded only during power-down |
| bclk | input | 1 | Serial bit clock |
| fclk | input | 1 | Frame clock that marks the left and right halves |
| sdin | input | 1 | Serial data line |
| left_word | output | 24 | Last received left sample, top-aligned |
| right_word | output | 24 | Last received right sample, top-aligned |
| word_valid | output | 1 | One-cycle strobe when a new pair is presented |
| fmt_err | output | 1 | Format error flag |

## Verification
The error check and the word strobe can fall in the same cycle. The half frame that shows 16 bits per half also completes a sample pair, so the pair emitted in that cycle must already be zero. This is provoked by sending 32-bit frames with codes 1 and 6. It is judged by checking that every presented word is zero, and that the flag stays set until power-down. In the other direction, the allowed 32-bit cases (codes 0 and 3) must deliver exact data with the flag low.

// File: rtl/sar_pkg.sv
package sar_pkg;

   localparam int SHORT_HALF = 16;   // bits per half frame in a 32-clock frame

   typedef struct packed {
      logic       rsvd;       // reserved code
      logic       lsb_just;   // word ends at the frame edge
      logic       late_msb;   // MSB one bit after the frame edge, left on low
      logic [5:0] nbits;      // fixed word length for LSB-justified codes
      logic       short_ok;   // 32-clock frame allowed
   } fmt_dec_t;

   function automatic fmt_dec_t decode_fmt(input logic [2:0] code);
      fmt_dec_t d;
      d = '{rsvd: 1'b0, lsb_just: 1'b0, late_msb: 1'b0, nbits: 6'd24, short_ok: 1'b0};
      case (code)
         3'd0: begin d.lsb_just = 1'b1; d.nbits = 6'd16; d.short_ok = 1'b1; end
         3'd1: begin d.lsb_just = 1'b1; d.nbits = 6'd20; end
         3'd2: ;
         3'd3: begin d.late_msb = 1'b1; d.short_ok = 1'b1; end
         3'd4: d.lsb_just = 1'b1;
         3'd5: ;
         3'd6: d.late_msb = 1'b1;
         default: d.rsvd = 1'b1;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sar_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sar_slicer.sv
module sar_slicer #(
   parameter int SLOT_MAX = 32,
   localparam int CNT_W   = $clog2(SLOT_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                bclk_i,
   input  logic                fclk_i,
   input  logic                sdin_i,
   input  logic                late_msb_i,
   output logic                half_done_o,
   output logic                half_mark_o,
   output logic [SLOT_MAX-1:0] half_sr_o,
   output logic [CNT_W-1:0]    half_cnt_o
);
   logic                bclk_q, lr_d1, mark_q, started;
   logic [SLOT_MAX-1:0] sr;
   logic [CNT_W-1:0]    cnt;
   logic                rise, marker, edge_seen;

   assign rise      = bclk_i & ~bclk_q;
   assign marker    = late_msb_i ? lr_d1 : fclk_i;
   assign edge_seen = marker ^ mark_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= bclk_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_d1 <= 1'b0; mark_q <= 1'b0; started <= 1'b0;
         sr <= '0; cnt <= '0;
         half_done_o <= 1'b0; half_mark_o <= 1'b0;
         half_sr_o <= '0; half_cnt_o <= '0;
      end else if (clr) begin
         lr_d1 <= 1'b0; mark_q <= 1'b0; started <= 1'b0;
         sr <= '0; cnt <= '0;
         half_done_o <= 1'b0;
      end else begin
         half_done_o <= 1'b0;
         if (rise) begin
            lr_d1  <= fclk_i;
            mark_q <= marker;
            if (edge_seen) begin
               if (started) begin
                  half_done_o <= 1'b1;
                  half_mark_o <= mark_q;
                  half_sr_o   <= sr;
                  half_cnt_o  <= cnt;
               end
               started <= 1'b1;
               sr      <= {{(SLOT_MAX-1){1'b0}}, sdin_i};
               cnt     <= CNT_W'(1);
            end else begin
               sr <= {sr[SLOT_MAX-2:0], sdin_i};
               if (cnt != CNT_W'(SLOT_MAX)) cnt <= cnt + 1'b1;
            end
         end
      end
   end

   p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(SLOT_MAX));
   p_half_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      half_done_o |=> !half_done_o);
endmodule

// File: rtl/sar_align.sv
module sar_align
   import sar_pkg::*;
#(
   parameter int WORD_W   = 24,
   parameter int SLOT_MAX = 32,
   localparam int CNT_W   = $clog2(SLOT_MAX + 1),
   localparam int SH_W    = (CNT_W > 6) ? CNT_W : 6,
   localparam int EXT_W   = SLOT_MAX + WORD_W
) (
   input  logic [SLOT_MAX-1:0] sr_i,
   input  logic [CNT_W-1:0]    cnt_i,
   input  fmt_dec_t            dec_i,
   output logic [WORD_W-1:0]   word_o
);
   logic [EXT_W-1:0] ext, shifted;
   logic [SH_W-1:0]  shamt;

   // Bits received sit in sr[cnt-1:0]; shifting {sr, zeros} right by k
   // leaves sr[k-1 -: WORD_W] on top, zero filled where fewer bits exist.
   assign ext     = {sr_i, {WORD_W{1'b0}}};
   assign shamt   = dec_i.lsb_just ? SH_W'(dec_i.nbits) : SH_W'(cnt_i);
   assign shifted = ext >> shamt;
   assign word_o  = shifted[WORD_W-1:0];
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int WORD_W      = 24,
   parameter int SLOT_MAX    = 32,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(SLOT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   input  logic [2:0]        fmt_sel,
   input  logic              bclk,
   input  logic              fclk,
   input  logic              sdin,
   output logic [WORD_W-1:0] left_word,
   output logic [WORD_W-1:0] right_word,
   output logic              word_valid,
   output logic              fmt_err
);
   generate
      if (WORD_W < 24) begin : g_bad_word
         $error("serial_audio_rx: WORD_W must be at least 24");
      end
      if (SLOT_MAX < WORD_W) begin : g_bad_slot
         $error("serial_audio_rx: SLOT_MAX must cover WORD_W");
      end
   endgenerate

   logic [2:0]          pins_s;
   logic [2:0]          fmt_q;
   fmt_dec_t            dec;
   logic                half_done, half_mark;
   logic [SLOT_MAX-1:0] half_sr;
   logic [CNT_W-1:0]    half_cnt;
   logic [WORD_W-1:0]   aligned, left_hold;
   logic                have_left, is_left, err_now, err_next;

   sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({bclk, fclk, sdin}), .q_o(pins_s));

   assign dec = decode_fmt(fmt_q);

   sar_slicer #(.SLOT_MAX(SLOT_MAX)) u_slicer (
      .clk(clk), .rst_n(rst_n), .clr(pwr_dn),
      .bclk_i(pins_s[2]), .fclk_i(pins_s[1]), .sdin_i(pins_s[0]),
      .late_msb_i(dec.late_msb),
      .half_done_o(half_done), .half_mark_o(half_mark),
      .half_sr_o(half_sr), .half_cnt_o(half_cnt));

   sar_align #(.WORD_W(WORD_W), .SLOT_MAX(SLOT_MAX)) u_align (
      .sr_i(half_sr), .cnt_i(half_cnt), .dec_i(dec), .word_o(aligned));

   assign is_left  = dec.late_msb ? ~half_mark : half_mark;
   assign err_now  = dec.rsvd |
                     (half_done & (half_cnt == CNT_W'(SHORT_HALF)) & ~dec.short_ok);
   assign err_next = fmt_err | err_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q <= '0; fmt_err <= 1'b0; word_valid <= 1'b0;
         left_word <= '0; right_word <= '0; left_hold <= '0; have_left <= 1'b0;
      end else if (pwr_dn) begin
         fmt_q <= fmt_sel; fmt_err <= 1'b0; word_valid <= 1'b0;
         left_word <= '0; right_word <= '0; left_hold <= '0; have_left <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         fmt_err    <= err_next;
         if (half_done) begin
            if (is_left) begin
               left_hold <= aligned;
               have_left <= 1'b1;
            end else if (have_left) begin
               word_valid <= 1'b1;
               left_word  <= err_next ? '0 : left_hold;
               right_word <= err_next ? '0 : aligned;
            end
         end
         if (fmt_err) begin
            left_word  <= '0;
            right_word <= '0;
         end
      end
   end

   p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |=> (left_word == '0 && right_word == '0));
   p_pdn_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> (!fmt_err && !word_valid && left_word == '0 && right_word == '0));
   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);
   p_fmt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_dn |=> $stable(fmt_q));
   p_rsvd_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_dn && dec.rsvd) |=> fmt_err);
endmodule

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
   logic        clk = 1'b0, rst_n = 1'b0, pwr_dn = 1'b1;
   logic [2:0]  fmt_sel = 3'd0;
   logic        bclk = 1'b0, fclk = 1'b0, sdin = 1'b0;
   logic [23:0] left_word, right_word;
   logic        word_valid, fmt_err;

   int checks = 0, errors = 0;
   int vcnt = 0, dbl = 0;
   logic prev_v = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   serial_audio_rx u0 (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .fmt_sel(fmt_sel),
      .bclk(bclk), .fclk(fclk), .sdin(sdin),
      .left_word(left_word), .right_word(right_word),
      .word_valid(word_valid), .fmt_err(fmt_err));

   always @(negedge clk) begin
      if (word_valid) vcnt++;
      if (word_valid && prev_v) dbl++;
      prev_v = word_valid;
   end

   // {code[2:0], clocks per frame[6:0], left[23:0], right[23:0], err}
   localparam int NV = 14;
   localparam logic [58:0] VEC [NV] = '{
      {3'd0, 7'd32, 24'hA5C3E1, 24'h1234AB, 1'b0},
      {3'd1, 7'd40, 24'h7F00F3, 24'h80FF0C, 1'b0},
      {3'd4, 7'd64, 24'hC0FFEE, 24'h0BEEF1, 1'b0},
      {3'd4, 7'd48, 24'h123456, 24'hFEDCBA, 1'b0},
      {3'd2, 7'd48, 24'h9ABCDE, 24'h13579F, 1'b0},
      {3'd5, 7'd40, 24'hF1E2D3, 24'h0C4B5A, 1'b0},
      {3'd5, 7'd64, 24'h3C5A7E, 24'hE1D2C3, 1'b0},
      {3'd3, 7'd32, 24'h8E7D6C, 24'h5B4A39, 1'b0},
      {3'd3, 7'd64, 24'h2468AC, 24'hDB9753, 1'b0},
      {3'd6, 7'd48, 24'h6A5B4C, 24'h97ABCD, 1'b0},
      {3'd6, 7'd32, 24'h4F3E2D, 24'hB0C1D2, 1'b1},
      {3'd7, 7'd64, 24'h111111, 24'h222222, 1'b1},
      {3'd1, 7'd32, 24'h765432, 24'h89ABCD, 1'b1},
      {3'd0, 7'd64, 24'h55AA33, 24'hAA55CC, 1'b0}
   };

   task automatic chk(bit ok, string rq, logic [23:0] act, logic [23:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   function automatic bit is_lsb(int f);
      return (f == 0 || f == 1 || f == 4 || f == 7);
   endfunction

   function automatic logic [23:0] exp_word(int f, int h, logic [23:0] w, bit e);
      int keep;
      logic [23:0] m;
      if (e) return 24'h0;
      if (f == 0)      keep = 16;
      else if (f == 1) keep = 20;
      else if (f == 4) keep = 24;
      else             keep = (h < 24) ? h : 24;
      m = 24'hFFFFFF;
      m = m << (24 - keep);
      return w & m;
   endfunction

   function automatic logic raw_bit(int f, int h, int k, logic [23:0] l, logic [23:0] r);
      int p, n;
      logic [23:0] w;
      p = k % h;
      w = (k >= h) ? r : l;
      n = (f == 0) ? 16 : (f == 1) ? 20 : 24;
      if (is_lsb(f)) return (p >= h - n) ? w[23 - (p - h + n)] : 1'b0;
      return (p < 24) ? w[23 - p] : 1'b0;
   endfunction

   task automatic send(int f, int bpf, logic [23:0] l, logic [23:0] r, int nfr);
      int h;
      bit late;
      h = bpf / 2;
      late = (f == 3 || f == 6);
      for (int fr = 0; fr < nfr; fr++) begin
         for (int k = 0; k < bpf; k++) begin
            fclk = late ? (k >= h) : (k < h);
            sdin = late ? raw_bit(f, h, (k + bpf - 1) % bpf, l, r) : raw_bit(f, h, k, l, r);
            bclk = 1'b0;
            repeat (4) @(negedge clk);
            bclk = 1'b1;
            repeat (4) @(negedge clk);
         end
      end
      bclk = 1'b0;
      repeat (40) @(negedge clk);
   endtask

   task automatic enter_pdn(logic [2:0] f);
      @(negedge clk);
      pwr_dn = 1'b1; fmt_sel = f; bclk = 1'b0; fclk = 1'b0; sdin = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(negedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      chk(left_word == 0 && right_word == 0, "R1 words in reset", left_word, 24'h0);
      chk(!word_valid && !fmt_err, "R1 flags in reset", {22'h0, word_valid, fmt_err}, 24'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // Table walk: R2 R3 R4 R5 R6 R8 R9 R11
      for (int i = 0; i < NV; i++) begin
         int f, bpf;
         logic [23:0] l, r;
         bit e;
         f = int'(VEC[i][58:56]); bpf = int'(VEC[i][55:49]);
         l = VEC[i][48:25]; r = VEC[i][24:1]; e = VEC[i][0];
         enter_pdn(3'(f));
         chk(!fmt_err && left_word == 0, "R10 cleared in power-down", {23'h0, fmt_err}, 24'h0);
         pwr_dn = 1'b0;
         vcnt = 0; dbl = 0;
         repeat (5) @(negedge clk);
         if (f == 7)
            chk(fmt_err == 1'b1, "R8 reserved code flags error", {23'h0, fmt_err}, 24'h1);
         send(f, bpf, l, r, 4);
         chk(left_word == exp_word(f, bpf / 2, l, e), $sformatf("R2/R3/R4/R5/R11 left code %0d frame %0d", f, bpf),
             left_word, exp_word(f, bpf / 2, l, e));
         chk(right_word == exp_word(f, bpf / 2, r, e), $sformatf("R2/R3/R4/R5/R11 right code %0d frame %0d", f, bpf),
             right_word, exp_word(f, bpf / 2, r, e));
         chk(fmt_err == e, $sformatf("R9 error flag code %0d frame %0d", f, bpf), {23'h0, fmt_err}, {23'h0, e});
         chk(vcnt >= 2 && vcnt <= 3 && dbl == 0, "R6 one single-cycle strobe per frame",
             24'(vcnt), 24'd3);
      end

      // R7: code change outside power-down is ignored
      enter_pdn(3'd4);
      pwr_dn = 1'b0;
      repeat (3) @(negedge clk);
      fmt_sel = 3'd0;
      send(4, 64, 24'h13579B, 24'hECA864, 4);
      chk(left_word == 24'h13579B, "R7 left keeps latched code", left_word, 24'h13579B);
      chk(right_word == 24'hECA864, "R7 right keeps latched code", right_word, 24'hECA864);

      // R9 then R10: error holds zero until power-down clears it
      enter_pdn(3'd4);
      pwr_dn = 1'b0;
      repeat (3) @(negedge clk);
      send(4, 32, 24'h7A7A7A, 24'h3B3B3B, 3);
      chk(fmt_err && left_word == 0 && right_word == 0, "R9 short frame zeroes words",
          left_word | right_word, 24'h0);
      @(negedge clk); pwr_dn = 1'b1;
      repeat (3) @(negedge clk);
      chk(!fmt_err && left_word == 0 && !word_valid, "R10 power-down clears error",
          {23'h0, fmt_err}, 24'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule